// File: doc/BRIEF.md
# Freezable Direct-Mapped Instruction Cache

This block is a 4-Kbyte direct-mapped instruction cache. It sits between a processor fetch port and a simple word-return bus port. Each line holds four 32-bit words and has one valid bit. On a miss the cache asks the bus for the whole line. The bus returns the requested word first, and the cache hands it to the fetch port in the same cycle. The remaining three words follow in ascending order, wrapping modulo four, and are written into the array while fetch goes on. The line becomes valid only after its last word has been written.

The array is divided into four 1-Kbyte quarters, each selected by address bits [11:10]. Each quarter has a freeze input. A fetch that misses in a frozen quarter is served with a single word from the bus, and the stored line stays as it is. Software preloads frozen contents through a diagnostic port that writes a tag (which also marks the line valid) and single data words. The cache comes out of reset disabled. While it is disabled, every fetch is passed through to the bus as a single-word read. An invalidate-all input clears every valid bit in one cycle.

Top module: `ifetch_cache`

## Requirements
- R1: While `cfg_enable` is 0 (its state after reset), every fetch causes a bus request with `bus_line`=0. The fetch is acknowledged with the returned bus word, and later fetches to the same address issue new bus requests.
- R2: With the cache enabled, a fetch whose line is valid and whose tag (address bits [31:12]) matches is acknowledged in the same cycle it is presented. It returns the stored word selected by bits [3:2] and raises no bus request.
- R3: An enabled miss in an unfrozen quarter raises `bus_req` for one cycle with `bus_line`=1. `bus_addr` equals the fetch address with bits [1:0] cleared.
- R4: The first returned word of any bus request is acknowledged on the fetch port in the cycle `bus_rvalid` is high, with `fetch_data` equal to `bus_rdata`.
- R5: A line fill stores beat k (k=0..3) into word (w+k) mod 4, where w is the requested word. Once the fill is complete, all four words hit with their bus values.
- R6: During the rest of a fill, a fetch to the same line stalls until its word has been written and then returns it without a new bus request. A fetch to any other line waits until the fill ends, and no bus request is raised while a request is outstanding.
- R7: An enabled miss in a quarter whose `cfg_freeze` bit (index = address bits [11:10]) is set raises a request with `bus_line`=0. It leaves the stored line, including a preloaded one, unchanged.
- R8: A diagnostic tag write stores `diag_tag` at `diag_index` and marks that line valid. A diagnostic data write stores `diag_wdata` at word `diag_word` of line `diag_index`.
- R9: A cycle with `inv_all` high clears every valid bit, so the next fetch to any previously cached line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Cache enable; 0 means bypass |
| cfg_freeze | input | 4 | Per-quarter freeze bits, indexed by address bits [11:10] |
| inv_all | input | 1 | Clear all valid bits |
| fetch_req | input | 1 | Fetch request, held until acknowledged |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ack | output | 1 | Fetch completed this cycle |
| fetch_data | output | 32 | Fetched word, valid with `fetch_ack` |
| bus_req | output | 1 | One-cycle bus read request |
| bus_addr | output | 32 | Word-aligned address of the requested word |
| bus_line | output | 1 | 1 = return four words in wrap order, 0 = one word |
| bus_rvalid | input | 1 | Bus returns a word this cycle |
| bus_rdata | input | 32 | Returned word |
| diag_tag_we | input | 1 | Diagnostic tag write (also sets valid) |
| diag_data_we | input | 1 | Diagnostic data word write |
| diag_index | input | 8 | Line index for diagnostic writes |
| diag_word | input | 2 | Word within the line for data writes |
| diag_tag | input | 20 | Tag value for tag writes |
| diag_wdata | input | 32 | Data value for data writes |

## Verification
The refill sequencer writing the array in the background and the fetch port looking up that same line can fall in the same cycle. To provoke this, the bench issues a fetch for the word that arrives last, right after the critical word has been acknowledged, with the bus inserting idle cycles between beats. The bench judges the overlap as correct when that fetch stalls for one or more cycles, returns the bus value for its address, and causes no extra bus request. It also checks that a fetch to a different line issued during the fill waits, then gets its own request and correct data.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int ADDR_W         = 32;
    localparam int WORD_W         = 32;
    localparam int WORDS_PER_LINE = 4;
    localparam int LINE_CNT       = 256;
    localparam int REGION_CNT     = 4;

    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int OFF_W  = $clog2(WORDS_PER_LINE);
    localparam int IDX_W  = $clog2(LINE_CNT);
    localparam int REG_W  = $clog2(REGION_CNT);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [OFF_W-1:0]  woff_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        tag_t  tag;
        idx_t  idx;
        woff_t off;
    } line_addr_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FIRST = 2'd1,
        SEQ_REST  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic we;
        idx_t idx;
        tag_t tag;
        logic valid;
    } tag_wr_t;

    typedef struct packed {
        logic  we;
        idx_t  idx;
        woff_t off;
        word_t data;
    } data_wr_t;

    function automatic line_addr_t split_addr(input logic [ADDR_W-1:0] a);
        line_addr_t r;
        r.tag = a[ADDR_W-1 -: TAG_W];
        r.idx = a[BYTE_W+OFF_W +: IDX_W];
        r.off = a[BYTE_W +: OFF_W];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] region_of(input idx_t i);
        return i[IDX_W-1 -: REG_W];
    endfunction
endpackage

// File: rtl/ic_tag_store.sv
module ic_tag_store
    import icache_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    inv_all,
    input  tag_wr_t wr,
    input  idx_t    rd_idx,
    output tag_t    rd_tag,
    output logic    rd_valid
);
    logic [LINE_CNT-1:0] valid_q;
    tag_t                tags_q [LINE_CNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (inv_all) begin
            valid_q <= '0;
        end else if (wr.we) begin
            valid_q[wr.idx] <= wr.valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr.we) begin
            tags_q[wr.idx] <= wr.tag;
        end
    end

    assign rd_tag   = tags_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

    // R9: invalidate-all leaves no line valid
    a_r9_inv_clears_all: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (valid_q == '0));

    // R8: a tag write lands at its index
    a_r8_tag_stored: assert property (@(posedge clk) disable iff (rst)
        wr.we |=> (tags_q[$past(wr.idx)] == $past(wr.tag)));
endmodule

// File: rtl/ic_data_store.sv
module ic_data_store
    import icache_pkg::*;
(
    input  logic     clk,
    input  data_wr_t wr,
    input  idx_t     rd_idx,
    input  woff_t    rd_off,
    output word_t    rd_data
);
    word_t mem_q [LINE_CNT][WORDS_PER_LINE];

    always_ff @(posedge clk) begin
        if (wr.we) begin
            mem_q[wr.idx][wr.off] <= wr.data;
        end
    end

    assign rd_data = mem_q[rd_idx][rd_off];
endmodule

// File: rtl/ic_refill_seq.sv
module ic_refill_seq
    import icache_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic [REGION_CNT-1:0] freeze,
    input  logic                  fetch_req,
    input  line_addr_t            fa,
    input  logic                  hit,
    input  word_t                 arr_word,
    input  logic                  bus_rvalid,
    input  word_t                 bus_rdata,
    output logic                  fetch_ack,
    output word_t                 fetch_data,
    output logic                  bus_req,
    output logic                  bus_line,
    output tag_wr_t               tag_wr,
    output data_wr_t              data_wr
);
    seq_state_t                state_q;
    logic                      line_q;
    idx_t                      idx_q;
    tag_t                      tag_q;
    woff_t                     crit_q;
    woff_t                     cnt_q;
    logic [WORDS_PER_LINE-1:0] got_q;

    localparam woff_t LAST_BEAT = woff_t'(WORDS_PER_LINE - 1);

    logic  same_line;
    logic  want_line;
    woff_t beat_off;

    assign same_line = enable && (fa.idx == idx_q) && (fa.tag == tag_q) && line_q;
    assign want_line = enable && !freeze[region_of(fa.idx)];
    assign beat_off  = crit_q + cnt_q;

    always_comb begin
        fetch_ack  = 1'b0;
        fetch_data = '0;
        bus_req    = 1'b0;
        bus_line   = 1'b0;
        tag_wr     = '0;
        data_wr    = '0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (fetch_req) begin
                    if (hit) begin
                        fetch_ack  = 1'b1;
                        fetch_data = arr_word;
                    end else begin
                        bus_req  = 1'b1;
                        bus_line = want_line;
                        if (want_line) begin
                            tag_wr = '{we: 1'b1, idx: fa.idx, tag: fa.tag, valid: 1'b0};
                        end
                    end
                end
            end
            SEQ_FIRST: begin
                if (bus_rvalid) begin
                    fetch_ack  = 1'b1;
                    fetch_data = bus_rdata;
                    if (line_q) begin
                        data_wr = '{we: 1'b1, idx: idx_q, off: crit_q, data: bus_rdata};
                    end
                end
            end
            SEQ_REST: begin
                if (bus_rvalid) begin
                    data_wr = '{we: 1'b1, idx: idx_q, off: beat_off, data: bus_rdata};
                    if (cnt_q == LAST_BEAT) begin
                        tag_wr = '{we: 1'b1, idx: idx_q, tag: tag_q, valid: 1'b1};
                    end
                end
                if (fetch_req && same_line && got_q[fa.off]) begin
                    fetch_ack  = 1'b1;
                    fetch_data = arr_word;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            line_q  <= 1'b0;
            idx_q   <= '0;
            tag_q   <= '0;
            crit_q  <= '0;
            cnt_q   <= '0;
            got_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (fetch_req && !hit) begin
                        state_q <= SEQ_FIRST;
                        line_q  <= want_line;
                        idx_q   <= fa.idx;
                        tag_q   <= fa.tag;
                        crit_q  <= fa.off;
                        cnt_q   <= '0;
                        got_q   <= '0;
                    end
                end
                SEQ_FIRST: begin
                    if (bus_rvalid) begin
                        if (line_q) begin
                            state_q        <= SEQ_REST;
                            got_q[crit_q]  <= 1'b1;
                            cnt_q          <= woff_t'(1);
                        end else begin
                            state_q <= SEQ_IDLE;
                        end
                    end
                end
                SEQ_REST: begin
                    if (bus_rvalid) begin
                        got_q[beat_off] <= 1'b1;
                        cnt_q           <= cnt_q + woff_t'(1);
                        if (cnt_q == LAST_BEAT) begin
                            state_q <= SEQ_IDLE;
                            line_q  <= 1'b0;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R6: a single request outstanding at a time
    a_r6_no_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q != SEQ_IDLE) |-> !bus_req);

    // R5: the closing beat finds the other three words already in place
    a_r5_full_before_valid: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_REST && bus_rvalid && cnt_q == LAST_BEAT)
            |-> ($countones(got_q) == WORDS_PER_LINE - 1));

    // R4: the first beat is forwarded to fetch at once
    a_r4_first_beat_forwarded: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_FIRST && bus_rvalid) |-> (fetch_ack && fetch_data == bus_rdata));
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
    import icache_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_enable,
    input  logic [REGION_CNT-1:0] cfg_freeze,
    input  logic                  inv_all,
    input  logic                  fetch_req,
    input  logic [ADDR_W-1:0]     fetch_addr,
    output logic                  fetch_ack,
    output logic [WORD_W-1:0]     fetch_data,
    output logic                  bus_req,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic                  bus_line,
    input  logic                  bus_rvalid,
    input  logic [WORD_W-1:0]     bus_rdata,
    input  logic                  diag_tag_we,
    input  logic                  diag_data_we,
    input  logic [IDX_W-1:0]      diag_index,
    input  logic [OFF_W-1:0]      diag_word,
    input  logic [TAG_W-1:0]      diag_tag,
    input  logic [WORD_W-1:0]     diag_wdata
);
    line_addr_t fa;
    tag_t       rd_tag;
    logic       rd_valid;
    word_t      arr_word;
    logic       hit;
    tag_wr_t    seq_tag_wr, tag_wr;
    data_wr_t   seq_data_wr, data_wr;

    assign fa  = split_addr(fetch_addr);
    assign hit = cfg_enable && rd_valid && (rd_tag == fa.tag);

    always_comb begin
        if (seq_tag_wr.we) tag_wr = seq_tag_wr;
        else tag_wr = '{we: diag_tag_we, idx: diag_index, tag: diag_tag, valid: 1'b1};
        if (seq_data_wr.we) data_wr = seq_data_wr;
        else data_wr = '{we: diag_data_we, idx: diag_index, off: diag_word, data: diag_wdata};
    end

    assign bus_addr = {fetch_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};

    ic_tag_store u_tags (
        .clk      (clk),
        .rst      (rst),
        .inv_all  (inv_all),
        .wr       (tag_wr),
        .rd_idx   (fa.idx),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid)
    );

    ic_data_store u_data (
        .clk     (clk),
        .wr      (data_wr),
        .rd_idx  (fa.idx),
        .rd_off  (fa.off),
        .rd_data (arr_word)
    );

    ic_refill_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .enable     (cfg_enable),
        .freeze     (cfg_freeze),
        .fetch_req  (fetch_req),
        .fa         (fa),
        .hit        (hit),
        .arr_word   (arr_word),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .fetch_ack  (fetch_ack),
        .fetch_data (fetch_data),
        .bus_req    (bus_req),
        .bus_line   (bus_line),
        .tag_wr     (seq_tag_wr),
        .data_wr    (seq_data_wr)
    );

    // R1: no line fill while disabled
    a_r1_bypass_single: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !cfg_enable) |-> !bus_line);

    // R7: frozen quarter is never refilled
    a_r7_frozen_no_fill: assert property (@(posedge clk) disable iff (rst)
        (bus_req && cfg_freeze[region_of(fa.idx)]) |-> !bus_line);

    // R2: a hit completes without touching the bus
    a_r2_hit_no_bus: assert property (@(posedge clk) disable iff (rst)
        fetch_ack |-> !bus_req);
endmodule

// File: tb/ifetch_cache_bench.sv
module ifetch_cache_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_enable;
    logic [3:0]  cfg_freeze;
    logic        inv_all;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ack;
    logic [31:0] fetch_data;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_line;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        diag_tag_we, diag_data_we;
    logic [7:0]  diag_index;
    logic [1:0]  diag_word;
    logic [19:0] diag_tag;
    logic [31:0] diag_wdata;

    int checks = 0;
    int errors = 0;
    int req_cnt = 0;
    logic last_line = 1'b0;
    logic [31:0] last_addr = '0;
    int gap = 1;

    always #5 clk = ~clk;

    ifetch_cache u_ifetch_cache (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_freeze(cfg_freeze),
        .inv_all(inv_all), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_line(bus_line), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .diag_tag_we(diag_tag_we), .diag_data_we(diag_data_we),
        .diag_index(diag_index), .diag_word(diag_word), .diag_tag(diag_tag),
        .diag_wdata(diag_wdata)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3C3_0000;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // bus responder: wrap-order beats
    initial begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        forever begin
            @(negedge clk);
            if (bus_req) begin
                logic [31:0] a;
                logic        ln;
                a = bus_addr;
                ln = bus_line;
                req_cnt++;
                last_line = ln;
                last_addr = a;
                @(posedge clk);
                for (int k = 0; k < (ln ? 4 : 1); k++) begin
                    logic [1:0] w;
                    w = a[3:2] + k[1:0];
                    repeat (gap) @(posedge clk);
                    #1 bus_rvalid = 1'b1;
                    bus_rdata = mem_word({a[31:4], w, 2'b00});
                    @(posedge clk);
                    #1 bus_rvalid = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    task automatic do_fetch(input logic [31:0] a, output logic [31:0] d, output int waits);
        waits = 0;
        d = '0;
        @(posedge clk);
        #1 fetch_req = 1'b1;
        fetch_addr = a;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (fetch_ack) begin
                d = fetch_data;
                break;
            end
            waits++;
        end
        @(posedge clk);
        #1 fetch_req = 1'b0;
    endtask

    task automatic fetch_expect(input logic [31:0] a, input logic [31:0] exp,
                                input string req, output int waits);
        logic [31:0] d;
        do_fetch(a, d, waits);
        check(d == exp, req, d, exp);
    endtask

    task automatic settle();
        repeat (12) @(posedge clk);
    endtask

    task automatic test_reset_bypass();
        int w, r0;
        @(negedge clk);
        check(!fetch_ack && !bus_req, "R1 reset idle", {30'd0, fetch_ack, bus_req}, 0);
        r0 = req_cnt;
        fetch_expect(32'h0000_1004, mem_word(32'h0000_1004), "R1 bypass data", w);
        check(req_cnt == r0 + 1 && !last_line, "R1 single request", req_cnt - r0, 1);
        fetch_expect(32'h0000_1004, mem_word(32'h0000_1004), "R1 repeat data", w);
        check(req_cnt == r0 + 2, "R1 no caching", req_cnt - r0, 2);
        settle();
    endtask

    task automatic test_fill_and_overlap();
        int w, r0;
        cfg_enable = 1'b1;
        r0 = req_cnt;
        fetch_expect(32'h0000_1008, mem_word(32'h0000_1008), "R4 critical word", w);
        check(last_line && last_addr == 32'h0000_1008, "R3 line request", last_addr, 32'h1008);
        // word 1 arrives last (order 2,3,0,1)
        fetch_expect(32'h0000_1004, mem_word(32'h0000_1004), "R6 same line data", w);
        check(w > 0, "R6 same line stalls", w, 1);
        check(req_cnt == r0 + 1, "R6 no extra request", req_cnt - r0, 1);
        settle();
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a;
            a = 32'h0000_1000 + 32'(k * 4);
            fetch_expect(a, mem_word(a), "R5 wrapped word", w);
            check(w == 0, "R2 hit same cycle", w, 0);
        end
        check(req_cnt == r0 + 1, "R2 hits silent", req_cnt - r0, 1);
        settle();
    endtask

    task automatic test_other_line_waits();
        int w, r0;
        r0 = req_cnt;
        fetch_expect(32'h0000_2010, mem_word(32'h0000_2010), "R4 second fill", w);
        fetch_expect(32'h0000_3020, mem_word(32'h0000_3020), "R6 other line data", w);
        check(w >= 6, "R6 other line waits", w, 6);
        check(req_cnt == r0 + 2, "R6 own request", req_cnt - r0, 2);
        settle();
        fetch_expect(32'h0000_201C, mem_word(32'h0000_201C), "R5 filled line", w);
        check(w == 0, "R5 line valid", w, 0);
        settle();
    endtask

    task automatic diag_write_tag(input logic [7:0] idx, input logic [19:0] t);
        @(posedge clk);
        #1 diag_tag_we = 1'b1; diag_index = idx; diag_tag = t;
        @(posedge clk);
        #1 diag_tag_we = 1'b0;
    endtask

    task automatic diag_write_data(input logic [7:0] idx, input logic [1:0] wd,
                                   input logic [31:0] v);
        @(posedge clk);
        #1 diag_data_we = 1'b1; diag_index = idx; diag_word = wd; diag_wdata = v;
        @(posedge clk);
        #1 diag_data_we = 1'b0;
    endtask

    task automatic test_freeze();
        int w, r0;
        diag_write_tag(8'hC0, 20'h00055);
        for (int k = 0; k < 4; k++) diag_write_data(8'hC0, k[1:0], 32'hF000_0000 + 32'(k));
        cfg_freeze = 4'b1000;
        r0 = req_cnt;
        fetch_expect(32'h0005_5C04, 32'hF000_0001, "R8 preload hit", w);
        check(w == 0 && req_cnt == r0, "R8 no bus", req_cnt - r0, 0);
        fetch_expect(32'h0007_7C08, mem_word(32'h0007_7C08), "R7 frozen miss data", w);
        check(req_cnt == r0 + 1 && !last_line, "R7 single word", {31'd0, last_line}, 0);
        settle();
        fetch_expect(32'h0005_5C0C, 32'hF000_0003, "R7 preload kept", w);
        check(w == 0, "R7 still hits", w, 0);
        settle();
    endtask

    task automatic test_invalidate_and_disable();
        int w, r0;
        @(posedge clk);
        #1 inv_all = 1'b1;
        @(posedge clk);
        #1 inv_all = 1'b0;
        r0 = req_cnt;
        fetch_expect(32'h0000_1000, mem_word(32'h0000_1000), "R9 refetch data", w);
        check(req_cnt == r0 + 1 && last_line, "R9 miss after clear", req_cnt - r0, 1);
        settle();
        cfg_enable = 1'b0;
        r0 = req_cnt;
        fetch_expect(32'h0000_100C, mem_word(32'h0000_100C), "R1 disabled data", w);
        check(req_cnt == r0 + 1 && !last_line, "R1 disabled bypass", req_cnt - r0, 1);
        settle();
    endtask

    initial begin
        rst = 1'b1; cfg_enable = 1'b0; cfg_freeze = '0; inv_all = 1'b0;
        fetch_req = 1'b0; fetch_addr = '0;
        diag_tag_we = 1'b0; diag_data_we = 1'b0; diag_index = '0; diag_word = '0;
        diag_tag = '0; diag_wdata = '0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        test_reset_bypass();
        test_fill_and_overlap();
        test_other_line_waits();
        test_freeze();
        test_invalidate_and_disable();
        finish_run();
    end
endmodule